// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block gathers 128 level-sensitive interrupt sources and presents one interrupt request line to a processor. Each source can be masked on its own and carries a 6-bit priority level. When at least one source is both asserted and unmasked, the controller picks the winner, records its number, and raises the request line. It then stops arbitrating until software writes an explicit "ready for the next interrupt" bit. Software reads a status word to learn which source to service. If the recorded source has since gone away, the status word carries a spurious marker instead of a number.

Software talks to the block over a plain 32-bit register port: a byte address, a write strobe and write data, with read data that follows the address in the same cycle. The port has no valid/ready pair and never applies back-pressure. Every write completes on the clock edge where it is presented, and every read is answered combinationally from the current address. A configuration word and an idle word are provided as plain read/write storage for software.

Top module: `irqc_top`

## Requirements
- R1: After reset, the four mask words (0x84, 0xA4, 0xC4, 0xE4) read 0xFFFFFFFF, every priority word reads 0, the status word (0x40) reads 0x000000FF and `irq_out` is low.
- R2: A mask word reads back exactly the last value written to it. Bit b of mask word k belongs to source 32*k+b, and a 1 masks that source.
- R3: Source n's priority word sits at 0x100 + 4*n. Only bits [7:2] are stored, and all other bits read as 0.
- R4: A source that is masked or not asserted never causes `irq_out` to rise.
- R5: Among asserted unmasked sources, the one with the numerically smallest priority field is selected.
- R6: When priority fields are equal, the lowest source number is selected.
- R7: While a selection is held and its source is still asserted and unmasked, the status word reads the source number in bits [6:0], with all other bits 0.
- R8: Once `irq_out` is high, it and the held source number stay unchanged, even when higher-priority sources arrive, until a write to 0x48 with bit 0 set. A write to 0x48 with bit 0 clear has no effect.
- R9: After the acknowledge write, `irq_out` is low on the next cycle. Arbitration then resumes, and the request line rises again two cycles after the write if a candidate is present.
- R10: When nothing is held, or the held source has been deasserted or masked, the status word reads 0x000000FF: source field all ones and bit 7 set.
- R11: The configuration word (0x10) and the idle word (0x50) read back the last value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 12 | Register byte address |
| bus_wr | input | 1 | Write strobe, applied at the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| src_level | input | 128 | Level-sensitive interrupt inputs, one per source |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
A single-source walk over all 128 inputs first shows that a mask bit alone blocks the request. Unmasking that one source then yields its number, which exposes any mask-to-source misrouting. A second pattern asserts every source at once with priorities computed so that each value occurs exactly twice. Draining the winners one by one checks the priority order against the tie rule on every pair. Late arrival of a higher-priority source during a hold distinguishes a frozen selection from one that re-arbitrates too early. Withdrawing or masking a held source distinguishes a live status word from a stale latched one.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  // byte offsets of the register map
  localparam int unsigned OFS_CFG      = 'h010;
  localparam int unsigned OFS_STATUS   = 'h040;
  localparam int unsigned OFS_CTRL     = 'h048;
  localparam int unsigned OFS_IDLE     = 'h050;
  localparam int unsigned OFS_MASK0    = 'h084;
  localparam int unsigned MASK_STRIDE  = 'h020;
  localparam int unsigned OFS_PRIO0    = 'h100;
  localparam int unsigned PRIO_STRIDE  = 4;

  // field positions
  localparam int unsigned ACK_BIT      = 0;
  localparam int unsigned PRIO_LSB     = 2;

  typedef enum logic [1:0] {
    ST_OPEN = 2'd0,   // arbitration allowed
    ST_HELD = 2'd1,   // selection frozen, request high
    ST_REST = 2'd2    // one quiet cycle after acknowledge
  } hold_state_t;
endpackage

// File: rtl/irqc_regs.sv
module irqc_regs
  import irqc_pkg::*;
#(
  parameter int NUM_SRC = 128,
  parameter int PRIO_W  = 6,
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ADDR_W-1:0]         addr,
  input  logic                      wr,
  input  logic [DATA_W-1:0]         wdata,
  input  logic [DATA_W-1:0]         stat_word,
  output logic [DATA_W-1:0]         rdata,
  output logic [NUM_SRC-1:0]        mask_vec,
  output logic [NUM_SRC*PRIO_W-1:0] prio_flat,
  output logic                      ack_wr
);
  localparam int MASK_WORDS = NUM_SRC / DATA_W;

  logic [DATA_W-1:0] cfg_q, idle_q;
  logic [DATA_W-1:0] mask_q [MASK_WORDS];
  logic [PRIO_W-1:0] prio_q [NUM_SRC];

  assign ack_wr = wr && (addr == ADDR_W'(OFS_CTRL)) && wdata[ACK_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      idle_q <= '0;
    end else if (wr) begin
      if (addr == ADDR_W'(OFS_CFG))  cfg_q  <= wdata;
      if (addr == ADDR_W'(OFS_IDLE)) idle_q <= wdata;
    end
  end

  for (genvar w = 0; w < MASK_WORDS; w++) begin : g_mask
    logic hit;
    assign hit = wr && (addr == ADDR_W'(OFS_MASK0 + w * MASK_STRIDE));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   mask_q[w] <= '1;
      else if (hit) mask_q[w] <= wdata;
    end
    assign mask_vec[w*DATA_W +: DATA_W] = mask_q[w];
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_prio
    logic hit;
    assign hit = wr && (addr == ADDR_W'(OFS_PRIO0 + i * PRIO_STRIDE));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   prio_q[i] <= '0;
      else if (hit) prio_q[i] <= wdata[PRIO_LSB +: PRIO_W];
    end
    assign prio_flat[i*PRIO_W +: PRIO_W] = prio_q[i];
  end

  always_comb begin
    rdata = '0;
    if (addr == ADDR_W'(OFS_CFG))    rdata = cfg_q;
    if (addr == ADDR_W'(OFS_IDLE))   rdata = idle_q;
    if (addr == ADDR_W'(OFS_STATUS)) rdata = stat_word;
    for (int w = 0; w < MASK_WORDS; w++)
      if (addr == ADDR_W'(OFS_MASK0 + w * MASK_STRIDE)) rdata = mask_q[w];
    for (int i = 0; i < NUM_SRC; i++)
      if (addr == ADDR_W'(OFS_PRIO0 + i * PRIO_STRIDE))
        rdata[PRIO_LSB +: PRIO_W] = prio_q[i];
  end
endmodule

// File: rtl/irqc_arb.sv
module irqc_arb #(
  parameter int NUM_SRC = 128,
  parameter int PRIO_W  = 6,
  localparam int SRC_W  = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0]        req,
  input  logic [NUM_SRC*PRIO_W-1:0] prio_flat,
  output logic                      cand_any,
  output logic [SRC_W-1:0]          cand_idx
);
  logic [PRIO_W-1:0] best_p;

  // ascending scan with strict less-than: equal levels keep the lower index
  always_comb begin
    cand_any = 1'b0;
    cand_idx = '0;
    best_p   = '1;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (req[i] && (!cand_any || prio_flat[i*PRIO_W +: PRIO_W] < best_p)) begin
        cand_any = 1'b1;
        cand_idx = SRC_W'(i);
        best_p   = prio_flat[i*PRIO_W +: PRIO_W];
      end
    end
  end
endmodule

// File: rtl/irqc_hold.sv
module irqc_hold
  import irqc_pkg::*;
#(
  parameter int NUM_SRC = 128,
  parameter int DATA_W  = 32,
  localparam int SRC_W  = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cand_any,
  input  logic [SRC_W-1:0]   cand_idx,
  input  logic               ack_wr,
  input  logic [NUM_SRC-1:0] req,
  output logic               irq,
  output logic [SRC_W-1:0]   held_src,
  output logic [DATA_W-1:0]  stat_word
);
  localparam logic [DATA_W-1:0] SPUR_WORD = DATA_W'({1'b1, {SRC_W{1'b1}}});

  hold_state_t state_q;
  logic        held_live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_OPEN;
      held_src <= '0;
    end else begin
      case (state_q)
        ST_OPEN: if (cand_any) begin
          state_q  <= ST_HELD;
          held_src <= cand_idx;
        end
        ST_HELD: if (ack_wr) state_q <= ST_REST;
        default: state_q <= ST_OPEN;
      endcase
    end
  end

  assign irq       = (state_q == ST_HELD);
  assign held_live = req[held_src];
  assign stat_word = (irq && held_live) ? DATA_W'(held_src) : SPUR_WORD;
endmodule

// File: rtl/irqc_top.sv
module irqc_top #(
  parameter int NUM_SRC = 128,
  parameter int PRIO_W  = 6,
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32,
  localparam int SRC_W  = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_wr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic [NUM_SRC-1:0] src_level,
  output logic               irq_out
);
  logic [NUM_SRC-1:0]        mask_vec;
  logic [NUM_SRC-1:0]        req;
  logic [NUM_SRC*PRIO_W-1:0] prio_flat;
  logic                      ack_wr;
  logic                      cand_any;
  logic [SRC_W-1:0]          cand_idx;
  logic [SRC_W-1:0]          held_src;
  logic [DATA_W-1:0]         stat_word;

  assign req = src_level & ~mask_vec;

  irqc_regs #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr(bus_wr), .wdata(bus_wdata),
    .stat_word(stat_word), .rdata(bus_rdata), .mask_vec(mask_vec),
    .prio_flat(prio_flat), .ack_wr(ack_wr)
  );

  irqc_arb #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_arb (
    .req(req), .prio_flat(prio_flat), .cand_any(cand_any), .cand_idx(cand_idx)
  );

  irqc_hold #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .cand_any(cand_any), .cand_idx(cand_idx),
    .ack_wr(ack_wr), .req(req), .irq(irq_out), .held_src(held_src),
    .stat_word(stat_word)
  );
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
  parameter int SRC_W  = 7,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              irq_out,
  input logic              ack_wr,
  input logic              cand_any,
  input logic [SRC_W-1:0]  held_src,
  input logic [DATA_W-1:0] stat_word
);
  // R8: request stays up until acknowledged
  assert_hold_line_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_out && !ack_wr) |=> irq_out);

  // R8: held number frozen while request is up
  assert_hold_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_out && !ack_wr) |=> $stable(held_src));

  // R9: acknowledge forces a quiet cycle
  assert_quiet_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_out && ack_wr) |=> !irq_out);

  // R4: no candidate, no rise
  assert_no_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_out && !cand_any) |=> !irq_out);

  // R10: with nothing held the status shows the spurious marker
  assert_spur_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_out |-> (stat_word[SRC_W] && (stat_word[SRC_W-1:0] == '1)));
endmodule

bind irqc_top irqc_checker #(.SRC_W(SRC_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_out(irq_out), .ack_wr(ack_wr),
  .cand_any(cand_any), .held_src(held_src), .stat_word(stat_word)
);

// File: tb/sim_irqc_top.sv
`timescale 1ns/1ps
module sim_irqc_top;
  localparam int N = 128;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [11:0]  addr = '0;
  logic         wen = 1'b0;
  logic [31:0]  wdata = '0;
  logic [31:0]  rdata;
  logic [N-1:0] lvl = '0;
  logic         irq;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  irqc_top u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wen), .bus_wdata(wdata),
    .bus_rdata(rdata), .src_level(lvl), .irq_out(irq)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wen = 1'b1;
    @(negedge clk);
    wen = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic wait_n(input int k);
    repeat (k) @(negedge clk);
  endtask

  function automatic logic [11:0] mask_addr(input int k);
    return 12'(12'h084 + k * 12'h020);
  endfunction

  function automatic logic [11:0] prio_addr(input int n);
    return 12'(12'h100 + 4 * n);
  endfunction

  logic [31:0] v;
  logic [5:0]  pr [N];
  logic        live [N];

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    wait_n(1);

    // R1 reset state
    chk("R1 irq", {31'b0, irq}, 32'h0);
    for (int k = 0; k < 4; k++) begin
      rd(mask_addr(k), v); chk("R1 mask", v, 32'hFFFF_FFFF);
    end
    for (int n = 0; n < N; n += 17) begin
      rd(prio_addr(n), v); chk("R1 prio", v, 32'h0);
    end
    rd(12'h040, v); chk("R1 status", v, 32'h0000_00FF);

    // R2 mask read-back
    for (int k = 0; k < 4; k++)
      for (int p = 0; p < 4; p++) begin
        logic [31:0] pat;
        pat = 32'h9E37_79B9 * (k * 4 + p + 1);
        wr(mask_addr(k), pat);
        rd(mask_addr(k), v); chk("R2 mask readback", v, pat);
      end
    for (int k = 0; k < 4; k++) wr(mask_addr(k), 32'hFFFF_FFFF);

    // R3 priority field storage
    for (int n = 0; n < N; n++) begin
      wr(prio_addr(n), 32'hFFFF_FFFF);
      rd(prio_addr(n), v); chk("R3 prio field", v, 32'h0000_00FC);
      wr(prio_addr(n), 32'h0);
    end

    // R11 plain storage
    wr(12'h010, 32'h1);          rd(12'h010, v); chk("R11 cfg", v, 32'h1);
    wr(12'h050, 32'h0);          rd(12'h050, v); chk("R11 idle", v, 32'h0);
    wr(12'h010, 32'h1357_9BDF);  rd(12'h010, v); chk("R11 cfg", v, 32'h1357_9BDF);
    wr(12'h050, 32'hCAFE_0042);  rd(12'h050, v); chk("R11 idle", v, 32'hCAFE_0042);

    // R4 / R7 / R9 single-source walk
    for (int n = 0; n < N; n++) begin
      lvl = '0; lvl[n] = 1'b1;
      wait_n(2);
      chk("R4 masked stays low", {31'b0, irq}, 32'h0);
      wr(mask_addr(n / 32), ~(32'h1 << (n % 32)));
      wait_n(1);
      chk("R4 unmasked raises", {31'b0, irq}, 32'h1);
      rd(12'h040, v); chk("R7 status number", v, 32'(n));
      wr(12'h048, 32'h1);
      chk("R9 low after ack", {31'b0, irq}, 32'h0);
      wait_n(2);
      chk("R9 rearbitrates", {31'b0, irq}, 32'h1);
      wr(mask_addr(n / 32), 32'hFFFF_FFFF);
      wr(12'h048, 32'h1);
      wait_n(2);
      chk("R4 remasked low", {31'b0, irq}, 32'h0);
      lvl = '0;
    end

    // R5 / R6 full-load drain with paired priorities
    for (int n = 0; n < N; n++) begin
      pr[n] = 6'((n * 37 + 5) % 64);
      live[n] = 1'b1;
      wr(prio_addr(n), {24'b0, pr[n], 2'b00});
    end
    for (int k = 0; k < 4; k++) wr(mask_addr(k), 32'h0);
    lvl = '1;
    for (int s = 0; s < N; s++) begin
      int best;
      best = -1;
      for (int i = 0; i < N; i++)
        if (live[i] && (best < 0 || pr[i] < pr[best])) best = i;
      wait_n(2);
      chk("R5 irq during drain", {31'b0, irq}, 32'h1);
      rd(12'h040, v); chk("R5 R6 winner", v, 32'(best));
      lvl[best] = 1'b0;
      live[best] = 1'b0;
      wr(12'h048, 32'h1);
    end
    wait_n(3);
    chk("R4 drained low", {31'b0, irq}, 32'h0);
    rd(12'h040, v); chk("R10 idle spurious", v, 32'h0000_00FF);

    // R8 hold against a later, stronger source
    wr(prio_addr(10), 32'(20 << 2));
    wr(prio_addr(3),  32'(5 << 2));
    lvl[10] = 1'b1;
    wait_n(2);
    rd(12'h040, v); chk("R7 held 10", v, 32'd10);
    lvl[3] = 1'b1;
    wait_n(3);
    chk("R8 still high", {31'b0, irq}, 32'h1);
    rd(12'h040, v); chk("R8 no reselect", v, 32'd10);
    wr(12'h048, 32'h2);
    wait_n(2);
    chk("R8 bit0 clear ignored", {31'b0, irq}, 32'h1);
    rd(12'h040, v); chk("R8 bit0 clear ignored", v, 32'd10);
    wr(12'h048, 32'h1);
    chk("R9 gap", {31'b0, irq}, 32'h0);
    wait_n(2);
    rd(12'h040, v); chk("R5 stronger wins", v, 32'd3);

    // R10 held source withdrawn
    lvl[3] = 1'b0;
    rd(12'h040, v); chk("R10 withdrawn", v, 32'h0000_00FF);
    chk("R8 line kept", {31'b0, irq}, 32'h1);
    wr(12'h048, 32'h1);
    wait_n(2);
    rd(12'h040, v); chk("R7 next is 10", v, 32'd10);
    lvl[10] = 1'b0;
    wr(12'h048, 32'h1);
    wait_n(2);
    chk("R4 none left", {31'b0, irq}, 32'h0);

    // R10 held source masked
    lvl[50] = 1'b1;
    wait_n(2);
    rd(12'h040, v); chk("R7 held 50", v, 32'd50);
    wr(mask_addr(1), 32'h1 << 18);
    rd(12'h040, v); chk("R10 masked", v, 32'h0000_00FF);
    chk("R8 line kept", {31'b0, irq}, 32'h1);
    wr(12'h048, 32'h1);
    wait_n(3);
    chk("R4 masked no rise", {31'b0, irq}, 32'h0);
    lvl = '0;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule